// File: doc/BRIEF.md
# Ping-Pong Sample Capture Controller

This block takes a stream of converter results and writes them into two alternating buffer banks. While one bank fills, a consumer can process the other. Each result arrives as a 12-bit value with a one-cycle valid strobe. The block drives a write enable, a write address and write data for each bank. Every sample written is one 16-bit word. Its upper four bits are zero.

Filling starts in bank 0 after reset. When the active bank takes its last entry, the block raises a full flag for that bank and moves capture to the other bank. The consumer re-arms a bank by acknowledging its flag. This clears the flag and rewinds that bank's address to zero.

If capture has to move to a bank that is still unacknowledged, the block stalls and raises an overrun flag. Samples that arrive during the stall are dropped. When the bank is acknowledged, capture resumes in it from address zero.

The controller is a four-state machine:
- `ST_FILL0`: writing bank 0.
- `ST_FILL1`: writing bank 1.
- `ST_WAIT0`: stalled, waiting for bank 0 to be re-armed.
- `ST_WAIT1`: stalled, waiting for bank 1 to be re-armed.

Its transitions are:
- From `ST_FILL0`, the last entry goes to `ST_FILL1` when bank 1 is free. It goes to `ST_WAIT1` when bank 1 is still full.
- From `ST_FILL1`, the last entry goes to `ST_FILL0` when bank 0 is free. It goes to `ST_WAIT0` when bank 0 is still full.
- From `ST_WAIT0`, an acknowledge of bank 0 goes to `ST_FILL0`.
- From `ST_WAIT1`, an acknowledge of bank 1 goes to `ST_FILL1`.

Top module: `pingpong_capture`

## Requirements
- R1: Each cycle with `smp_valid` high in a fill state writes exactly one word into the active bank, at that bank's current address. The address then steps by one, and it is observable on the write port in the same cycle as the strobe.
- R2: Only the active bank's write enable may be high. The inactive bank's enable stays low whatever the strobe does.
- R3: After reset, capture starts in bank 0. Once each bank fills, capture moves to the other bank, so the banks are used in the order 0, 1, 0, 1 and so on.
- R4: The strobe that writes address DEPTH-1 of the active bank sets that bank's flag (`bank_full[0]` for bank 0, `bank_full[1]` for bank 1) from the next cycle. The next sample goes to the other bank. A set flag stays set until acknowledged.
- R5: The write data is the 12-bit sample in bits 11:0, with bits 15:12 zero.
- R6: `bank_ack[b]` high while `bank_full[b]` is set clears that flag in the next cycle and rewinds bank b's address to 0. An acknowledge of a bank whose flag is clear has no effect on flags or addresses.
- R7: If a bank fills while the other bank's flag is set and not being acknowledged, `overrun` goes high from the next cycle. No write happens until that bank is acknowledged. Capture then resumes in that bank at address 0, and `overrun` goes low.
- R8: An acknowledge of the other bank in the same cycle as the last write of the active bank avoids the overrun, and capture switches at once.
- R9: Reset clears both flags and `overrun`, and sets both addresses to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_data | input | 12 | Converter result |
| bank_ack | input | 2 | Per-bank re-arm acknowledge |
| wr_en0 | output | 1 | Bank 0 write enable |
| wr_addr0 | output | ADDR_W | Bank 0 write address |
| wr_data0 | output | 16 | Bank 0 write data |
| wr_en1 | output | 1 | Bank 1 write enable |
| wr_addr1 | output | ADDR_W | Bank 1 write address |
| wr_data1 | output | 16 | Bank 1 write data |
| bank_full | output | 2 | Per-bank full flags |
| overrun | output | 1 | Capture stalled on an unacknowledged bank |

## Verification
The embedded properties check these rules on every cycle:
- The two write enables are never high together.
- An active fill state never targets a flagged bank.
- A flag holds until it is acknowledged and clears right after the acknowledge.
- Nothing is written while `overrun` is high.
- Addresses stay within the bank depth.

Only the bench scenarios show the following:
- The exact address sequence.
- The zero-extended data.
- The order 0, 1, 0, 1 in which the banks are used.
- An acknowledge of a clear flag being ignored.
- Acknowledge timing on the switch cycle deciding between a clean switch and an overrun.

// File: rtl/pp_capture_pkg.sv
package pp_capture_pkg;

    typedef enum logic [1:0] {
        ST_FILL0 = 2'd0,
        ST_FILL1 = 2'd1,
        ST_WAIT0 = 2'd2,
        ST_WAIT1 = 2'd3
    } cap_state_e;

endpackage

// File: rtl/pp_addr_ctr.sv
module pp_addr_ctr #(
    parameter int DEPTH  = 1600,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              clr,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);

    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);

    assign last = (addr == TOP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clr) begin
            addr <= '0;
        end else if (inc && !last) begin
            addr <= addr + 1'b1;
        end
    end

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        addr <= TOP); // R1
    AST_CLR_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (addr == '0)); // R6

endmodule

// File: rtl/pp_capture_fsm.sv
module pp_capture_fsm
    import pp_capture_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_valid,
    input  logic [1:0] bank_ack,
    input  logic [1:0] last,
    output logic [1:0] inc,
    output logic [1:0] clr,
    output logic [1:0] full_q,
    output logic       overrun_q
);

    cap_state_e state_q, state_d;
    logic [1:0] done;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL0: begin
                if (smp_valid && last[0]) begin
                    state_d = (full_q[1] && !bank_ack[1]) ? ST_WAIT1 : ST_FILL1;
                end
            end
            ST_FILL1: begin
                if (smp_valid && last[1]) begin
                    state_d = (full_q[0] && !bank_ack[0]) ? ST_WAIT0 : ST_FILL0;
                end
            end
            ST_WAIT0: if (bank_ack[0]) state_d = ST_FILL0;
            ST_WAIT1: if (bank_ack[1]) state_d = ST_FILL1;
            default:  state_d = ST_FILL0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FILL0;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        inc = 2'b00;
        unique case (state_q)
            ST_FILL0: inc[0] = smp_valid;
            ST_FILL1: inc[1] = smp_valid;
            ST_WAIT0, ST_WAIT1: inc = 2'b00;
            default:  inc = 2'b00;
        endcase
        done = inc & last;
        clr  = bank_ack & full_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q    <= 2'b00;
            overrun_q <= 1'b0;
        end else begin
            for (int b = 0; b < 2; b++) begin
                if (done[b])     full_q[b] <= 1'b1;
                else if (clr[b]) full_q[b] <= 1'b0;
            end
            overrun_q <= (state_d == ST_WAIT0) || (state_d == ST_WAIT1);
        end
    end

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inc)); // R2
    AST_FILL0_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL0) |-> !full_q[0]); // R7
    AST_FILL1_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL1) |-> !full_q[1]); // R7
    AST_FLAG_HOLD0: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q[0] && !bank_ack[0]) |=> full_q[0]); // R4
    AST_FLAG_HOLD1: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q[1] && !bank_ack[1]) |=> full_q[1]); // R4
    AST_ACK_CLEAR0: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q[0] && bank_ack[0]) |=> !full_q[0]); // R6
    AST_ACK_CLEAR1: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q[1] && bank_ack[1]) |=> !full_q[1]); // R6
    AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_q |-> (inc == 2'b00)); // R7
    AST_STALL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_q |-> (full_q != 2'b00)); // R7

endmodule

// File: rtl/pingpong_capture.sv
module pingpong_capture #(
    parameter int SAMPLE_W = 12,
    parameter int WORD_W   = 16,
    parameter int DEPTH    = 1600,
    parameter int ADDR_W   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [1:0]          bank_ack,
    output logic                wr_en0,
    output logic [ADDR_W-1:0]   wr_addr0,
    output logic [WORD_W-1:0]   wr_data0,
    output logic                wr_en1,
    output logic [ADDR_W-1:0]   wr_addr1,
    output logic [WORD_W-1:0]   wr_data1,
    output logic [1:0]          bank_full,
    output logic                overrun
);

    localparam int PAD_W = WORD_W - SAMPLE_W;

    logic [1:0]        inc, clr, last;
    logic [ADDR_W-1:0] addr [2];
    logic [WORD_W-1:0] word;

    assign word = {{PAD_W{1'b0}}, smp_data};

    pp_capture_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .bank_ack  (bank_ack),
        .last      (last),
        .inc       (inc),
        .clr       (clr),
        .full_q    (bank_full),
        .overrun_q (overrun)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        pp_addr_ctr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc[b]),
            .clr   (clr[b]),
            .addr  (addr[b]),
            .last  (last[b])
        );
    end

    assign wr_en0   = inc[0];
    assign wr_en1   = inc[1];
    assign wr_addr0 = addr[0];
    assign wr_addr1 = addr[1];
    assign wr_data0 = word;
    assign wr_data1 = word;

    AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en0 && wr_en1)); // R2

endmodule

// File: tb/pingpong_capture_bench.sv
module pingpong_capture_bench;

    localparam int DEPTH = 4;
    localparam int AW    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [11:0]   smp_data = '0;
    logic [1:0]    bank_ack = '0;
    logic          wr_en0, wr_en1, overrun;
    logic [AW-1:0] wr_addr0, wr_addr1;
    logic [15:0]   wr_data0, wr_data1;
    logic [1:0]    bank_full;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pingpong_capture #(.DEPTH(DEPTH), .ADDR_W(AW)) u_pingpong_capture (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .bank_ack(bank_ack), .wr_en0(wr_en0), .wr_addr0(wr_addr0),
        .wr_data0(wr_data0), .wr_en1(wr_en1), .wr_addr1(wr_addr1),
        .wr_data1(wr_data1), .bank_full(bank_full), .overrun(overrun)
    );

    // {vld, ack[1:0], exp_en{1,0}, exp_addr, exp_full, exp_ovr}, seen before the edge
    localparam int NV = 21;
    localparam logic [9:0] VEC [NV] = '{
        {1'b1, 2'b00, 2'b01, 2'd0, 2'b00, 1'b0}, // R3 bank 0 first
        {1'b1, 2'b00, 2'b01, 2'd1, 2'b00, 1'b0},
        {1'b0, 2'b00, 2'b00, 2'd0, 2'b00, 1'b0},
        {1'b1, 2'b00, 2'b01, 2'd2, 2'b00, 1'b0},
        {1'b1, 2'b00, 2'b01, 2'd3, 2'b00, 1'b0}, // last of bank 0
        {1'b1, 2'b00, 2'b10, 2'd0, 2'b01, 1'b0}, // R4 switched
        {1'b1, 2'b00, 2'b10, 2'd1, 2'b01, 1'b0},
        {1'b1, 2'b00, 2'b10, 2'd2, 2'b01, 1'b0},
        {1'b1, 2'b00, 2'b10, 2'd3, 2'b01, 1'b0}, // bank 0 unacked
        {1'b1, 2'b00, 2'b00, 2'd0, 2'b11, 1'b1}, // R7 dropped
        {1'b0, 2'b01, 2'b00, 2'd0, 2'b11, 1'b1}, // re-arm bank 0
        {1'b1, 2'b00, 2'b01, 2'd0, 2'b10, 1'b0}, // R7 resume at 0
        {1'b1, 2'b10, 2'b01, 2'd1, 2'b10, 1'b0},
        {1'b1, 2'b00, 2'b01, 2'd2, 2'b00, 1'b0},
        {1'b1, 2'b00, 2'b01, 2'd3, 2'b00, 1'b0},
        {1'b1, 2'b00, 2'b10, 2'd0, 2'b01, 1'b0}, // R6 bank 1 rewound
        {1'b0, 2'b10, 2'b00, 2'd0, 2'b01, 1'b0}, // R6 stray ack
        {1'b1, 2'b00, 2'b10, 2'd1, 2'b01, 1'b0}, // address kept
        {1'b1, 2'b00, 2'b10, 2'd2, 2'b01, 1'b0},
        {1'b1, 2'b01, 2'b10, 2'd3, 2'b01, 1'b0}, // R8 ack on switch
        {1'b1, 2'b00, 2'b01, 2'd0, 2'b10, 1'b0}  // R8 no overrun
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #200000;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #4;
        // R9 reset state
        check("R9 full", int'(bank_full), 0);
        check("R9 overrun", int'(overrun), 0);
        check("R9 addr0", int'(wr_addr0), 0);
        check("R9 addr1", int'(wr_addr1), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [9:0] v;
            logic [11:0] d;
            v = VEC[i];
            d = 12'hF00 | 12'(i);
            smp_valid = v[9];
            bank_ack  = v[8:7];
            smp_data  = d;
            #4;
            check("R2 enables", int'({wr_en1, wr_en0}), int'(v[6:5]));
            if (v[5]) begin
                check("R1 addr0", int'(wr_addr0), int'(v[4:3]));
                check("R5 data0", int'(wr_data0), int'({4'h0, d}));
            end
            if (v[6]) begin
                check("R1 addr1", int'(wr_addr1), int'(v[4:3]));
                check("R5 data1", int'(wr_data1), int'({4'h0, d}));
            end
            check("R4 R6 flags", int'(bank_full), int'(v[2:1]));
            check("R7 overrun", int'(overrun), int'(v[0]));
            @(negedge clk);
        end

        // mid-stream reset: bank 0 was at address 1
        smp_valid = 1'b0;
        bank_ack  = 2'b00;
        rst_n     = 1'b0;
        @(negedge clk);
        rst_n     = 1'b1;
        smp_valid = 1'b1;
        smp_data  = 12'hABC;
        #4;
        check("R9 flags after reset", int'(bank_full), 0);
        check("R3 bank0 after reset", int'({wr_en1, wr_en0}), 1);
        check("R9 addr0 after reset", int'(wr_addr0), 0);
        check("R5 data", int'(wr_data0), 16'h0ABC);
        @(negedge clk);
        smp_valid = 1'b0;
        #4;
        check("R1 step", int'(wr_addr0), 1);
        check("R2 idle", int'({wr_en1, wr_en0}), 0);
        finish_run();
    end

endmodule